// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using two levels of storage. The first level holds recent branch outcomes in shift registers. Depending on a parameter, the block keeps either one shift register for every branch, or a small set of shift registers chosen by fetch-address bits. The second level is a bank of pattern tables. Each table holds one 2-bit saturating counter for every possible history value. Address bits pick the table, the current history picks the counter within it, and the counter's upper bit is the guess.

Lookup is combinational. The fetch stage presents a PC and gets back a direction bit, together with the exact counter index that produced it. The fetch stage keeps that index with the branch. When the branch resolves, the execute stage returns the PC, the real outcome and the saved index. The block then shifts the outcome into the history register that the PC selects. It also moves the counter named by the saved index one step toward the outcome.

Top module: `twolevel_dir_pred`

## Requirements
- R1: After reset, every counter holds weakly not-taken (2'b01) and every history register holds zero. The first lookup therefore returns pred_taken=0 with a zero history field in pred_index.
- R2: On a resolve, the selected history register shifts left by one. The outcome enters bit 0 (taken=1, not-taken=0) and the oldest bit is dropped.
- R3: A taken resolve increments the addressed counter, and the counter saturates at 2'b11.
- R4: A not-taken resolve decrements the addressed counter, and the counter saturates at 2'b00.
- R5: pred_index is {set, history}. The history field is bits [HIST_W-1:0]. The set field is the upper $clog2(NUM_TABLES) bits and equals lookup_pc[ALIGN_W +: $clog2(NUM_TABLES)]. pred_taken is bit 1 of the counter at that index.
- R6: In per-set mode, the history register is chosen by PC bits [ALIGN_W +: $clog2(NUM_HREGS)]. A resolve leaves every other history register unchanged.
- R7: In global mode, a single history register records every resolve, whatever the PC.
- R8: A resolve updates the counter named by resolve_index, not the one that the current history or resolve_pc would select.
- R9: When a lookup and a resolve address the same counter in the same cycle, the lookup returns the value from before the update.
- R10: A lookup on its own changes no state. With no resolve, the outputs for a given PC stay the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_pc | input | PC_W | Fetch address to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_index | output | SET_W+HIST_W | Counter index used: {set, history} |
| resolve_valid | input | 1 | A branch outcome is being returned this cycle |
| resolve_pc | input | PC_W | Address of the resolved branch |
| resolve_taken | input | 1 | Actual outcome, 1 = taken |
| resolve_index | input | SET_W+HIST_W | Index saved from the branch's lookup |

## Verification
The assertions assume that at most one resolve arrives per cycle and that resolve_index holds a legal {set, history} value. In practice that value is one pred_index has produced. The history-shift and no-effect properties compare consecutive lookups. They only judge cycles where the selected history register stayed the same, and they treat any change of PC select bits as out of scope. The stimulus meets these assumptions by drawing most resolves from a queue of earlier lookup indices, in order. The directed sequences use hand-picked indices, which keeps each update aimed at a known counter. Both organisations run side by side on the same inputs, one in per-set mode and one in global mode.

// File: rtl/tlp_pkg.sv
`timescale 1ns/1ps
package tlp_pkg;

    typedef enum logic {
        HIST_PER_SET = 1'b0,
        HIST_GLOBAL  = 1'b1
    } hist_mode_e;

    // weakly not-taken starting point for every counter
    localparam logic [1:0] CTR_RESET = 2'b01;

    // one saturating step toward the resolved direction
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic up);
        if (up) begin
            return (cur == 2'b11) ? cur : cur + 2'd1;
        end
        return (cur == 2'b00) ? cur : cur - 2'd1;
    endfunction

endpackage

// File: rtl/tlp_history.sv
`timescale 1ns/1ps
module tlp_history #(
    parameter int HIST_W   = 4,
    parameter int NUM_REGS = 8,
    parameter int SEL_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic              wr_taken
);

    typedef struct packed {
        logic [NUM_REGS-1:0][HIST_W-1:0] regs;
    } hist_state_t;

    hist_state_t st_d, st_q;

    // next state: only the register picked by the resolve shifts
    always_comb begin
        st_d = st_q;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (wr_en && wr_sel == SEL_W'(r)) begin
                st_d.regs[r] = {st_q.regs[r][HIST_W-2:0], wr_taken};
            end
        end
    end

    // read mux over the registered copies
    always_comb begin
        rd_hist = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (rd_sel == SEL_W'(r)) begin
                rd_hist = st_q.regs[r];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tlp_pattern.sv
`timescale 1ns/1ps
module tlp_pattern #(
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIST_W-1:0] rd_hist,
    output logic              rd_dir,
    input  logic              wr_en,
    input  logic [HIST_W-1:0] wr_hist,
    input  logic              wr_taken
);

    localparam int ENTRIES = 1 << HIST_W;

    typedef struct packed {
        logic [ENTRIES-1:0][1:0] ctr;
    } pat_state_t;

    localparam pat_state_t RESET_ST = pat_state_t'({ENTRIES{tlp_pkg::CTR_RESET}});

    pat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctr[wr_hist] = tlp_pkg::ctr_step(st_q.ctr[wr_hist], wr_taken);
        end
    end

    // upper counter bit is the direction; read sees pre-update state
    assign rd_dir = st_q.ctr[rd_hist][1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_ST;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/twolevel_dir_pred.sv
`timescale 1ns/1ps
module twolevel_dir_pred
    import tlp_pkg::*;
#(
    parameter int         PC_W       = 32,
    parameter int         ALIGN_W    = 2,
    parameter int         HIST_W     = 4,
    parameter int         NUM_TABLES = 4,
    parameter int         NUM_HREGS  = 8,
    parameter hist_mode_e HIST_MODE  = HIST_PER_SET,
    localparam int        SET_W      = $clog2(NUM_TABLES),
    localparam int        IDX_W      = SET_W + HIST_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  lookup_pc,
    output logic             pred_taken,
    output logic [IDX_W-1:0] pred_index,
    input  logic             resolve_valid,
    input  logic [PC_W-1:0]  resolve_pc,
    input  logic             resolve_taken,
    input  logic [IDX_W-1:0] resolve_index
);

    localparam int HREGS  = (HIST_MODE == HIST_GLOBAL) ? 1 : NUM_HREGS;
    localparam int HSEL_W = (HREGS > 1) ? $clog2(HREGS) : 1;

    logic [HSEL_W-1:0] lk_hsel, rs_hsel;
    logic [SET_W-1:0]  lk_set, rs_set;
    logic [HIST_W-1:0] lk_hist;
    logic [NUM_TABLES-1:0] tbl_dir;
    logic pc_unused;

    // first level: choose which history register a PC maps to
    generate
        if (HREGS == 1) begin : g_global_hist
            assign lk_hsel = '0;
            assign rs_hsel = '0;
        end else begin : g_set_hist
            assign lk_hsel = lookup_pc[ALIGN_W +: HSEL_W];
            assign rs_hsel = resolve_pc[ALIGN_W +: HSEL_W];
        end
    endgenerate

    assign pc_unused = ^{lookup_pc, resolve_pc};

    tlp_history #(
        .HIST_W  (HIST_W),
        .NUM_REGS(HREGS),
        .SEL_W   (HSEL_W)
    ) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_sel  (lk_hsel),
        .rd_hist (lk_hist),
        .wr_en   (resolve_valid),
        .wr_sel  (rs_hsel),
        .wr_taken(resolve_taken)
    );

    // second level: one pattern table per address set
    assign lk_set = lookup_pc[ALIGN_W +: SET_W];
    assign rs_set = resolve_index[IDX_W-1:HIST_W];

    generate
        for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
            tlp_pattern #(
                .HIST_W(HIST_W)
            ) u_pt (
                .clk     (clk),
                .rst_n   (rst_n),
                .rd_hist (lk_hist),
                .rd_dir  (tbl_dir[t]),
                .wr_en   (resolve_valid && (rs_set == SET_W'(t))),
                .wr_hist (resolve_index[HIST_W-1:0]),
                .wr_taken(resolve_taken)
            );
        end
    endgenerate

    assign pred_taken = tbl_dir[lk_set];
    assign pred_index = {lk_set, lk_hist};

endmodule

// File: rtl/tlp_checker.sv
`timescale 1ns/1ps
module tlp_checker
    import tlp_pkg::*;
#(
    parameter int         PC_W       = 32,
    parameter int         ALIGN_W    = 2,
    parameter int         HIST_W     = 4,
    parameter int         NUM_TABLES = 4,
    parameter int         NUM_HREGS  = 8,
    parameter hist_mode_e HIST_MODE  = HIST_PER_SET,
    localparam int        SET_W      = $clog2(NUM_TABLES),
    localparam int        IDX_W      = SET_W + HIST_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PC_W-1:0]  lookup_pc,
    input logic             pred_taken,
    input logic [IDX_W-1:0] pred_index,
    input logic             resolve_valid,
    input logic [PC_W-1:0]  resolve_pc,
    input logic             resolve_taken,
    input logic [IDX_W-1:0] resolve_index
);

    localparam int CK_HSEL_W = (HIST_MODE == HIST_GLOBAL) ? 1 :
                               ((NUM_HREGS > 1) ? $clog2(NUM_HREGS) : 1);

    logic [CK_HSEL_W-1:0] ck_lk_hsel, ck_rs_hsel;

    generate
        if (HIST_MODE == HIST_GLOBAL) begin : g_ck_global
            assign ck_lk_hsel = '0;
            assign ck_rs_hsel = '0;
        end else begin : g_ck_set
            assign ck_lk_hsel = lookup_pc[ALIGN_W +: CK_HSEL_W];
            assign ck_rs_hsel = resolve_pc[ALIGN_W +: CK_HSEL_W];
        end
    endgenerate

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!pred_taken && pred_index[HIST_W-1:0] == '0));

    assert_hist_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_valid && ck_lk_hsel == ck_rs_hsel) |=>
        (!$stable(ck_lk_hsel) ||
         pred_index[HIST_W-1:0] == {$past(pred_index[HIST_W-2:0]), $past(resolve_taken)}));

    assert_sat_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_valid && resolve_taken && resolve_index == pred_index && pred_taken) |=>
        (pred_index != $past(pred_index) || pred_taken));

    assert_sat_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_valid && !resolve_taken && resolve_index == pred_index && !pred_taken) |=>
        (pred_index != $past(pred_index) || !pred_taken));

    assert_hist_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!resolve_valid || ck_lk_hsel != ck_rs_hsel) |=>
        (!$stable(ck_lk_hsel) || $stable(pred_index[HIST_W-1:0])));

    assert_lookup_no_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !resolve_valid |=>
        (!$stable(lookup_pc) || ($stable(pred_taken) && $stable(pred_index))));

endmodule

bind twolevel_dir_pred tlp_checker #(
    .PC_W      (PC_W),
    .ALIGN_W   (ALIGN_W),
    .HIST_W    (HIST_W),
    .NUM_TABLES(NUM_TABLES),
    .NUM_HREGS (NUM_HREGS),
    .HIST_MODE (HIST_MODE)
) u_chk (.*);

// File: tb/twolevel_dir_pred_test.sv
`timescale 1ns/1ps
module twolevel_dir_pred_test;
    import tlp_pkg::*;

    localparam int PCW = 32;
    localparam int AL  = 2;
    localparam int HW  = 4;
    localparam int NT  = 4;
    localparam int NH  = 8;
    localparam int IW  = 6;
    localparam int NCTR = NT << HW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [PCW-1:0] lookup_pc = '0;
    logic [PCW-1:0] resolve_pc = '0;
    logic resolve_valid = 1'b0;
    logic resolve_taken = 1'b0;
    logic [IW-1:0] ridx_p = '0;
    logic [IW-1:0] ridx_g = '0;
    logic pred_p, pred_g;
    logic [IW-1:0] pidx_p, pidx_g;

    twolevel_dir_pred #(.PC_W(PCW), .ALIGN_W(AL), .HIST_W(HW), .NUM_TABLES(NT),
        .NUM_HREGS(NH), .HIST_MODE(HIST_PER_SET)) uut (
        .clk(clk), .rst_n(rst_n), .lookup_pc(lookup_pc), .pred_taken(pred_p),
        .pred_index(pidx_p), .resolve_valid(resolve_valid), .resolve_pc(resolve_pc),
        .resolve_taken(resolve_taken), .resolve_index(ridx_p));

    twolevel_dir_pred #(.PC_W(PCW), .ALIGN_W(AL), .HIST_W(HW), .NUM_TABLES(NT),
        .NUM_HREGS(NH), .HIST_MODE(HIST_GLOBAL)) uut_glb (
        .clk(clk), .rst_n(rst_n), .lookup_pc(lookup_pc), .pred_taken(pred_g),
        .pred_index(pidx_g), .resolve_valid(resolve_valid), .resolve_pc(resolve_pc),
        .resolve_taken(resolve_taken), .resolve_index(ridx_g));

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // behavioural reference state
    int hist_p[NH];
    int hist_g;
    int ctr_p[NCTR];
    int ctr_g[NCTR];

    function automatic int set_of(input logic [PCW-1:0] pc);
        return int'((pc >> AL) % NT);
    endfunction

    function automatic int hs_of(input logic [PCW-1:0] pc);
        return int'((pc >> AL) % NH);
    endfunction

    function automatic int sat(input int c, input bit up);
        if (up) return (c < 3) ? c + 1 : 3;
        return (c > 0) ? c - 1 : 0;
    endfunction

    function automatic int exp_idx_p(input logic [PCW-1:0] pc);
        return set_of(pc) * (1 << HW) + hist_p[hs_of(pc)];
    endfunction

    function automatic int exp_idx_g(input logic [PCW-1:0] pc);
        return set_of(pc) * (1 << HW) + hist_g;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NH; i++) hist_p[i] = 0;
        hist_g = 0;
        for (int i = 0; i < NCTR; i++) begin
            ctr_p[i] = 1;
            ctr_g[i] = 1;
        end
    endtask

    // one cycle: drive, compare both instances to the model, then advance the model
    task automatic step(input logic [PCW-1:0] lpc, input bit rv, input logic [PCW-1:0] rpc,
                        input bit rt, input int ip, input int ig, input string req);
        int xp, xg, ep, eg;
        @(negedge clk);
        lookup_pc = lpc;
        resolve_valid = rv;
        resolve_pc = rpc;
        resolve_taken = rt;
        ridx_p = IW'(ip);
        ridx_g = IW'(ig);
        #1;
        xp = exp_idx_p(lpc);
        xg = exp_idx_g(lpc);
        ep = (ctr_p[xp] >= 2) ? 1 : 0;
        eg = (ctr_g[xg] >= 2) ? 1 : 0;
        check(pred_p === 1'(ep), req, "per-set direction", int'(pred_p), ep);
        check(pidx_p === IW'(xp), req, "per-set index", int'(pidx_p), xp);
        check(pred_g === 1'(eg), req, "global direction", int'(pred_g), eg);
        check(pidx_g === IW'(xg), req, "global index", int'(pidx_g), xg);
        @(posedge clk);
        if (rv) begin
            ctr_p[ip] = sat(ctr_p[ip], rt);
            ctr_g[ig] = sat(ctr_g[ig], rt);
            hist_p[hs_of(rpc)] = ((hist_p[hs_of(rpc)] << 1) | int'(rt)) & ((1 << HW) - 1);
            hist_g = ((hist_g << 1) | int'(rt)) & ((1 << HW) - 1);
        end
    endtask

    task automatic peek(input logic [PCW-1:0] lpc);
        @(negedge clk);
        lookup_pc = lpc;
        resolve_valid = 1'b0;
        #1;
    endtask

    localparam logic [PCW-1:0] P = 32'h0000_0100; // set 0, history reg 0
    localparam logic [PCW-1:0] Q = 32'h0000_0104; // set 1, history reg 1

    initial begin
        int q_pc[$];
        int q_ip[$];
        int q_ig[$];
        int loop_cnt;
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen at the ports
        peek(P);
        check(pred_p === 1'b0, "R1", "per-set direction after reset", int'(pred_p), 0);
        check(pidx_p === 6'd0, "R1", "per-set index after reset", int'(pidx_p), 0);
        check(pred_g === 1'b0, "R1", "global direction after reset", int'(pred_g), 0);
        step(P, 1'b0, Q, 1'b0, 0, 0, "R1");

        // R9 first: same-cycle lookup and update of counter 0 returns old value
        step(P, 1'b1, Q, 1'b1, 0, 0, "R9");
        // R3: drive counter 0 to its upper limit via resolves at Q (R8: saved index rules)
        repeat (3) step(P, 1'b1, Q, 1'b1, 0, 0, "R3");
        peek(P);
        check(pred_p === 1'b1, "R3", "direction after taken run", int'(pred_p), 1);
        check(pidx_p[HW-1:0] === 4'd0, "R6", "untouched history reg", int'(pidx_p[HW-1:0]), 0);
        repeat (2) step(P, 1'b1, Q, 1'b0, 0, 0, "R3");
        peek(P);
        check(pred_p === 1'b0, "R3", "ceiling held at 11 then two decrements", int'(pred_p), 0);
        // R4: floor at 00, then two increments reach 10
        repeat (2) step(P, 1'b1, Q, 1'b0, 0, 0, "R4");
        repeat (2) step(P, 1'b1, Q, 1'b1, 0, 0, "R4");
        peek(P);
        check(pred_p === 1'b1, "R4", "floor held at 00 then two increments", int'(pred_p), 1);
        check(pidx_p[HW-1:0] === 4'd0, "R6", "history reg 0 after resolves at Q",
              int'(pidx_p[HW-1:0]), 0);
        check(pidx_g[HW-1:0] === 4'b0011, "R7", "global history", int'(pidx_g[HW-1:0]), 3);
        peek(Q);
        check(pidx_p === 6'd19, "R2", "per-set index at Q", int'(pidx_p), 19);
        check(pred_p === 1'b0, "R8", "table 1 untouched by index-0 updates", int'(pred_p), 0);
        peek(32'h0000_010C);
        check(pidx_p[IW-1:HW] === 2'd3, "R5", "set field from PC", int'(pidx_p[IW-1:HW]), 3);

        // R10: lookups only, then the same PC again
        for (int i = 0; i < 20; i++) begin
            step(32'h0000_0200 + 32'(i * 4), 1'b0, Q, 1'b1, 63, 63, "R10");
        end
        peek(P);
        check(pred_p === 1'b1, "R10", "direction after lookup-only cycles", int'(pred_p), 1);
        check(pidx_g[HW-1:0] === 4'b0011, "R10", "global history after lookups",
              int'(pidx_g[HW-1:0]), 3);

        // mixed traffic: resolves replay earlier lookups in order
        loop_cnt = 0;
        for (int n = 0; n < 4000; n++) begin
            logic [PCW-1:0] lpc;
            logic [PCW-1:0] rpc;
            bit rv, rt;
            int ip, ig;
            lpc = 32'h0000_1000 + 32'($urandom_range(0, 15) << AL);
            rv = 1'b0; rt = 1'b0; rpc = '0; ip = 0; ig = 0;
            if (q_pc.size() > 0 && $urandom_range(0, 9) < 6) begin
                rv = 1'b1;
                rpc = 32'(q_pc.pop_front());
                ip = q_ip.pop_front();
                ig = q_ig.pop_front();
                if (rpc[4]) rt = ($urandom_range(0, 3) != 0);
                else begin
                    rt = ((loop_cnt % 3) != 2);
                    loop_cnt++;
                end
            end
            if (q_pc.size() < 8 && $urandom_range(0, 9) < 6) begin
                q_pc.push_back(int'(lpc));
                q_ip.push_back(exp_idx_p(lpc));
                q_ig.push_back(exp_idx_g(lpc));
            end
            step(lpc, rv, rpc, rt, ip, ig, "R5");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL all watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule